// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Timer

This block is the free-running bit-rate timer of a serial port. It counts system clock cycles through a fixed prescaler and then through a programmable divisor, and produces two single-cycle strobes: an oversample tick for a receiver's sampling logic and a bit tick that paces a transmitter. Each bit period holds a whole number of oversample ticks, so the two strobes stay locked together.

Three mode inputs choose the rate law. In asynchronous low-speed mode the prescaler divides by 4 and a bit spans 16 oversample ticks, giving a bit every 64 x (X+1) clocks. Asynchronous high-speed mode keeps the prescale of 4 but spans only 4 oversample ticks per bit, which is 16 x (X+1) clocks. Synchronous mode bypasses the prescaler, spans 4 ticks per bit and ignores the high-speed select, which is 4 x (X+1) clocks. X is the divisor. Its low byte always counts. Its high byte counts only when the wide-divisor select is set.

Software loads the divisor one byte at a time through two write strobes that share a data bus. Any divisor write restarts the count from the beginning. Raising the enable has the same effect, so the first strobes after a restart fall a full period later.

Top module: `baud_gen`

## Requirements
- R1: While rst_ni is low or en_i is low, os_tick_o and bit_tick_o stay 0. The cycle in which en_i is first seen high restarts the count exactly as a divisor write does (R7).
- R2: With sync_i=0 and hispeed_i=0, os_tick_o pulses every 4 x (X+1) cycles and bit_tick_o pulses every 64 x (X+1) cycles.
- R3: With sync_i=0 and hispeed_i=1, os_tick_o pulses every 4 x (X+1) cycles and bit_tick_o pulses every 16 x (X+1) cycles.
- R4: With sync_i=1, os_tick_o pulses every (X+1) cycles and bit_tick_o pulses every 4 x (X+1) cycles, whatever the value of hispeed_i.
- R5: With wide_i=0, X equals the low divisor byte, and the stored high byte has no effect on either period.
- R6: With wide_i=1, X = high_byte x 256 + low_byte, with the high byte in bits 15:8.
- R7: A clock edge with div_lo_we_i or div_hi_we_i high loads div_wdata_i into the low or high byte and restarts the timer. Both ticks are 0 in the following cycle. The first os_tick_o comes one oversample period after that edge, and the first bit_tick_o comes one bit period after it.
- R8: Every bit_tick_o pulse coincides with an os_tick_o pulse. bit_tick_o is never high in two consecutive cycles. A bit period holds exactly 16 oversample ticks in async low-speed mode and 4 in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| sync_i | input | 1 | 1 = synchronous-mode rate law |
| hispeed_i | input | 1 | 1 = high-speed async rate (ignored when sync_i=1) |
| wide_i | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| div_lo_we_i | input | 1 | Write strobe for the low divisor byte |
| div_hi_we_i | input | 1 | Write strobe for the high divisor byte |
| div_wdata_i | input | 8 | Divisor byte write data |
| os_tick_o | output | 1 | Single-cycle oversample strobe |
| bit_tick_o | output | 1 | Single-cycle bit-rate strobe |

## Verification
The assertions check four things on every cycle: both strobes are quiet while disabled and in the cycle after a divisor write, a bit strobe always lands on an oversample strobe, and a bit strobe never repeats in the next cycle. The exact periods of the three rate laws, the disregard of the high byte in 8-bit mode and of the speed select in synchronous mode, and the timing of the first strobe after a mid-period rewrite or an enable are shown only by the bench's sweeps. Those sweeps measure the cycle gaps against arithmetic from the rate formulas.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PRE_ASYNC = 4;
  localparam int unsigned PRE_SYNC  = 1;
  localparam int unsigned OSR_LOW   = 16;
  localparam int unsigned OSR_HIGH  = 4;
  localparam int unsigned OSR_SYNC  = 4;
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg #(
  parameter int unsigned BYTE_W = baud_pkg::BYTE_W,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wide_i,
  output logic [DIV_W-1:0]  div_o
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i;
    end
  end

  // high byte only counts in wide mode
  assign div_o = {(wide_i ? hi_q : {BYTE_W{1'b0}}), lo_q};
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned PRE_ASYNC = baud_pkg::PRE_ASYNC,
  parameter int unsigned PRE_SYNC  = baud_pkg::PRE_SYNC,
  localparam int unsigned PW = (PRE_ASYNC > 1) ? $clog2(PRE_ASYNC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sync_i,
  output logic tick_o
);
  localparam logic [PW-1:0] LAST_ASYNC = PW'(PRE_ASYNC - 1);
  localparam logic [PW-1:0] LAST_SYNC  = PW'(PRE_SYNC - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last   = sync_i ? LAST_SYNC : LAST_ASYNC;
  assign tick_o = !clr_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt #(
  parameter int unsigned DIV_W = 2 * baud_pkg::BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // up-count against the live divisor so a same-edge write is honoured
  assign tick_o = step_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_bitcnt.sv
module baud_bitcnt #(
  parameter int unsigned OSR_LOW  = baud_pkg::OSR_LOW,
  parameter int unsigned OSR_HIGH = baud_pkg::OSR_HIGH,
  parameter int unsigned OSR_SYNC = baud_pkg::OSR_SYNC,
  localparam int unsigned CW = $clog2(OSR_LOW)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic sync_i,
  input  logic hispeed_i,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST_LOW  = CW'(OSR_LOW - 1);
  localparam logic [CW-1:0] LAST_HIGH = CW'(OSR_HIGH - 1);
  localparam logic [CW-1:0] LAST_SYNC = CW'(OSR_SYNC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  // sync mode ignores the speed select
  always_comb begin
    if (sync_i)         last = LAST_SYNC;
    else if (hispeed_i) last = LAST_HIGH;
    else                last = LAST_LOW;
  end

  assign tick_o = step_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned BYTE_W = baud_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              hispeed_i,
  input  logic              wide_i,
  input  logic              div_lo_we_i,
  input  logic              div_hi_we_i,
  input  logic [BYTE_W-1:0] div_wdata_i,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  localparam int unsigned DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0] div_val;
  logic             en_q, clr, pre_tick, os_c, bit_c;

  // enable edge acts like a divisor write
  assign clr = !(en_i && en_q) || div_lo_we_i || div_hi_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      os_tick_o  <= 1'b0;
      bit_tick_o <= 1'b0;
    end else begin
      en_q       <= en_i;
      os_tick_o  <= !clr && os_c;
      bit_tick_o <= !clr && bit_c;
    end
  end

  baud_divreg #(.BYTE_W(BYTE_W)) u_divreg (
    .clk_i, .rst_ni,
    .lo_we_i(div_lo_we_i), .hi_we_i(div_hi_we_i),
    .wdata_i(div_wdata_i), .wide_i, .div_o(div_val)
  );

  baud_prescale u_pre (
    .clk_i, .rst_ni, .clr_i(clr), .sync_i, .tick_o(pre_tick)
  );

  baud_divcnt #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(pre_tick),
    .div_i(div_val), .tick_o(os_c)
  );

  baud_bitcnt u_bit (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(os_c),
    .sync_i, .hispeed_i, .tick_o(bit_c)
  );

  assert_quiet_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!os_tick_o && !bit_tick_o));

  assert_quiet_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_lo_we_i || div_hi_we_i) |=> (!os_tick_o && !bit_tick_o));

  assert_bit_on_os_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  assert_bit_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);
endmodule

// File: tb/tb_baud_gen.sv
`timescale 1ns/1ps
module tb_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic sync_m = 1'b0, hs = 1'b0, wide = 1'b0;
  logic lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic os_t, bit_t;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  baud_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_i(sync_m),
    .hispeed_i(hs), .wide_i(wide), .div_lo_we_i(lo_we),
    .div_hi_we_i(hi_we), .div_wdata_i(wdata),
    .os_tick_o(os_t), .bit_tick_o(bit_t)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // strobe at one edge, return just after it
  task automatic kick(input bit lo, input bit hi, input logic [7:0] d);
    @(negedge clk);
    lo_we = lo; hi_we = hi; wdata = d;
    @(posedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (os_t || bit_t) hits++;
    end
    chk(hits == 0, tag, "ticks while quiet", hits, 0);
  endtask

  // called right after the restarting edge
  task automatic measure(input int x, input string tag);
    int p, nos, t_os, t_bit;
    int os1 = -1, os2 = -1, b1 = -1, b2 = -1, os_in_bit = 0;
    int orphan = 0, dbl = 0;
    logic prev_os = 1'b0;
    p   = sync_m ? 1 : 4;
    nos = (sync_m || hs) ? 4 : 16;
    t_os  = p * (x + 1);
    t_bit = nos * t_os;
    @(negedge clk);
    lo_we = 1'b0; hi_we = 1'b0;
    chk(!os_t && !bit_t, "R7", "ticks right after restart", {os_t, bit_t}, 0);
    for (int c = 1; c <= 2 * t_bit + 1; c++) begin
      @(negedge clk);
      if (os_t) begin
        if (os1 < 0) os1 = c; else if (os2 < 0) os2 = c;
        if (b1 < 0) os_in_bit++;
        if (prev_os && t_os > 1) dbl++;
      end
      if (bit_t) begin
        if (!os_t) orphan++;
        if (b1 < 0) b1 = c; else if (b2 < 0) b2 = c;
      end
      prev_os = os_t;
    end
    chk(os1 == t_os, tag, "first os tick cycle", os1, t_os);
    chk(os2 - os1 == t_os, tag, "os period", os2 - os1, t_os);
    chk(b1 == t_bit, tag, "first bit tick cycle", b1, t_bit);
    chk(b2 - b1 == t_bit, tag, "bit period", b2 - b1, t_bit);
    chk(os_in_bit == nos, "R8", "os ticks per bit", os_in_bit, nos);
    chk(orphan == 0, "R8", "bit tick without os tick", orphan, 0);
    chk(dbl == 0, "R8", "os tick longer than one cycle", dbl, 0);
  endtask

  task automatic run(input bit s, input bit h, input bit w,
                     input logic [7:0] lo, input logic [7:0] hi, input string tag);
    int x;
    sync_m = s; hs = h; wide = w;
    kick(1'b0, 1'b1, hi);
    kick(1'b1, 1'b0, lo);
    x = w ? (int'(hi) * 256 + int'(lo)) : int'(lo);
    measure(x, tag);
  endtask

  initial begin
    byte unsigned los [4] = '{8'd0, 8'd1, 8'd2, 8'd7};
    repeat (3) @(negedge clk);
    chk(!os_t && !bit_t, "R1", "ticks in reset", {os_t, bit_t}, 0);
    rst_n = 1'b1;
    quiet(100, "R1");

    // enable restarts like a write: lo=3, async low speed
    kick(1'b1, 1'b0, 8'd3);
    @(negedge clk); lo_we = 1'b0;
    quiet(20, "R1");
    @(negedge clk); en = 1'b1;
    @(posedge clk);
    measure(3, "R1");

    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 4; i++) begin
        // R5: stored high byte 0xA5 must not count when narrow
        case (m)
          0: run(1'b0, 1'b0, 1'b0, los[i], 8'hA5, "R2 R5");
          1: run(1'b0, 1'b1, 1'b0, los[i], 8'hA5, "R3 R5");
          2: run(1'b1, 1'b0, 1'b0, los[i], 8'hA5, "R4");
          default: run(1'b1, 1'b1, 1'b0, los[i], 8'hA5, "R4 hispeed ignored");
        endcase
      end
    end

    run(1'b0, 1'b1, 1'b1, 8'd3, 8'd1, "R6");
    run(1'b1, 1'b0, 1'b1, 8'd0, 8'd2, "R6");
    run(1'b0, 1'b0, 1'b1, 8'd5, 8'd0, "R6");

    // R7: mid-period rewrite of the low byte restarts
    run(1'b0, 1'b0, 1'b0, 8'd9, 8'd0, "R7");
    repeat (37) @(negedge clk);
    kick(1'b1, 1'b0, 8'd2);
    measure(2, "R7");
    // R7: high-byte-only write also restarts (wide, X = 0x100 + 2)
    sync_m = 1'b1; wide = 1'b1;
    repeat (11) @(negedge clk);
    kick(1'b0, 1'b1, 8'd1);
    measure(258, "R7");

    // R1: disable mid-run, then re-enable
    @(negedge clk); en = 1'b0;
    quiet(200, "R1");
    @(negedge clk); en = 1'b1;
    @(posedge clk);
    measure(258, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule